// File: doc/BRIEF.md
# Serial Clock and Parameter Memory

This block is a battery-domain style timekeeper with a small byte memory. A host reaches it through three port lines: an active-low select, a serial clock and one data line whose direction the host controls. Every transfer starts with a command byte. The command picks one of four seconds bytes, one byte of parameter memory, the write-protect flag, a scratch test location, or an extended two-byte memory address. Read data is shifted back to the host on the same data line.

The block runs from the system clock. It detects serial clock edges by comparing each sample with the one before, so the serial clock must run well below the system clock. A one-second tick input advances the 32-bit seconds count. A preset strobe loads the count from a Unix-style timestamp, converted to a count that starts at the first day of 1904.

Top module: `serial_rtc_pram`

## Requirements
- R1: While `ser_en_n` is high, serial clock edges have no effect. Raising `ser_en_n` in the middle of a byte drops the partial byte and makes the next byte a command.
- R2: While `host_drive` is 1, each rising edge of `ser_clk` shifts `ser_din` in. The first bit is the byte's bit 7.
- R3: After a read command, each falling edge of `ser_clk` while `host_drive` is 0 puts the next bit of the read byte on `ser_dout`, bit 7 first, for 8 bits. Falling edges after the 8th bit leave `ser_dout` unchanged.
- R4: Commands 0x81, 0x85, 0x89 and 0x8D return seconds bytes 0, 1, 2 and 3, where byte 0 is the least significant.
- R5: Write commands 0x01, 0x05, 0x09 and 0x0D followed by a data byte replace seconds bytes 0 to 3 and leave the other bytes unchanged.
- R6: Each cycle with `sec_tick` high adds one to the seconds count, unless a preset or a host write to the count occurs in that cycle.
- R7: A cycle with `preset_stb` high loads the seconds count with `preset_unix` + 2082844800, modulo 2^32. A preset takes priority over a host write and over a tick.
- R8: Command 0x35 followed by a data byte loads the write-protect flag from bit 0 of the data byte. Command 0x35 is accepted whatever the flag's value. While the flag is 1, every other write has no effect.
- R9: Command 0x31 takes a data byte and discards it. No stored byte changes.
- R10: A command of the form z010aa01 (binary) reaches memory byte 0x10+aa. A command of the form z1aaaa01 reaches memory byte aaaa. Bit z, the command's bit 7, is 1 for a read and 0 for a write.
- R11: A command of the form z0111sss starts an extended access. The next byte gives the offset in bits 6:2, and its other bits are ignored. The memory index is sss×8 + offset. A read returns that byte after the second byte. A write takes a third byte as data.
- R12: After reset, the seconds count is 0, the write-protect flag is clear and `ser_dout` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sec_tick | input | 1 | One-second advance pulse |
| preset_stb | input | 1 | Load the seconds count from `preset_unix` |
| preset_unix | input | 32 | Unix-epoch seconds used by a preset |
| ser_en_n | input | 1 | Serial select, active low |
| ser_clk | input | 1 | Serial clock from the host |
| ser_din | input | 1 | Data line value while the host drives it |
| host_drive | input | 1 | 1 when the host drives the data line |
| ser_dout | output | 1 | Data line value returned to the host |

## Verification
Plain memory commands are tried in both the 0x10–0x13 window and the 0x00–0x0F window, with data bytes whose bit patterns are not palindromes. This shows whether bits come out MSB first or reversed. An extended write is read back through a plain command at the same index, which tells a correct sector×8+offset index from a shifted or swapped one. The extended read also uses an address byte with its unused bits set. Seconds bytes are read after a preset, after ticks and after a single-byte write, which shows byte order and whether writes reach the other bytes. Write-protect, the test register, a transfer with the select high and an aborted partial byte are each followed by readbacks. These readbacks show that nothing stored changed.

// File: rtl/rtcp_pkg.sv
package rtcp_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [31:0] EPOCH_OFFSET = 32'd2082844800;

  typedef enum logic [1:0] {PH_CMD, PH_WDATA, PH_XADDR, PH_XWDATA} phase_e;
  typedef enum logic [1:0] {WR_NONE, WR_SECS, WR_PRAM, WR_WP} wr_kind_e;

  localparam logic [7:0] CMD_WPROT = 8'h35;
  localparam logic [7:0] CMD_TEST  = 8'h31;

  // command classes, independent of the read flag in bit 7
  function automatic logic is_secs(input logic [7:0] b);
    return (b[6:4] == 3'b000) && (b[1:0] == 2'b01);
  endfunction
  function automatic logic is_hi_pram(input logic [7:0] b);
    return (b[6:4] == 3'b010) && (b[1:0] == 2'b01);
  endfunction
  function automatic logic is_lo_pram(input logic [7:0] b);
    return b[6] && (b[1:0] == 2'b01);
  endfunction
  function automatic logic is_ext(input logic [7:0] b);
    return b[6:3] == 4'b0111;
  endfunction
endpackage

// File: rtl/rtcp_shifter.sv
module rtcp_shifter
  import rtcp_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              sclk,
  input  logic              din,
  input  logic              host_drive,
  input  logic              load_out,
  input  logic [BYTE_W-1:0] load_byte,
  output logic              byte_vld,
  output logic [BYTE_W-1:0] byte_val,
  output logic              dout
);
  localparam int unsigned CW = $clog2(BYTE_W);

  logic              sclk_q;
  logic [BYTE_W-2:0] in_sh_q, in_sh_n;
  logic [CW-1:0]     in_cnt_q, in_cnt_n;
  logic              vld_q, vld_n;
  logic [BYTE_W-1:0] byte_q, byte_n;
  logic [BYTE_W-1:0] out_sh_q, out_sh_n;
  logic [CW:0]       out_cnt_q, out_cnt_n;
  logic              dout_q, dout_n;
  logic              rise, fall;

  assign rise = sclk & ~sclk_q & ~en_n & host_drive;
  assign fall = ~sclk & sclk_q & ~en_n & ~host_drive;

  always_comb begin
    in_sh_n  = in_sh_q;
    in_cnt_n = in_cnt_q;
    vld_n    = 1'b0;
    byte_n   = byte_q;
    if (en_n) begin
      in_cnt_n = '0;
    end else if (rise) begin
      in_sh_n  = {in_sh_q[BYTE_W-3:0], din};
      in_cnt_n = CW'(in_cnt_q + 1'b1);
      if (in_cnt_q == CW'(BYTE_W - 1)) begin
        vld_n  = 1'b1;
        byte_n = {in_sh_q, din};
      end
    end
  end

  always_comb begin
    out_sh_n  = out_sh_q;
    out_cnt_n = out_cnt_q;
    dout_n    = dout_q;
    if (en_n) begin
      out_cnt_n = '0;
    end else if (load_out) begin
      out_sh_n  = load_byte;
      out_cnt_n = (CW+1)'(BYTE_W);
    end else if (fall && (out_cnt_q != '0)) begin
      dout_n    = out_sh_q[BYTE_W-1];
      out_sh_n  = {out_sh_q[BYTE_W-2:0], 1'b0};
      out_cnt_n = out_cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sclk_q    <= 1'b0;
      in_sh_q   <= '0;
      in_cnt_q  <= '0;
      vld_q     <= 1'b0;
      byte_q    <= '0;
      out_sh_q  <= '0;
      out_cnt_q <= '0;
      dout_q    <= 1'b0;
    end else begin
      sclk_q    <= sclk;
      in_sh_q   <= in_sh_n;
      in_cnt_q  <= in_cnt_n;
      vld_q     <= vld_n;
      byte_q    <= byte_n;
      out_sh_q  <= out_sh_n;
      out_cnt_q <= out_cnt_n;
      dout_q    <= dout_n;
    end
  end

  assign byte_vld = vld_q;
  assign byte_val = byte_q;
  assign dout     = dout_q;
endmodule

// File: rtl/rtcp_ctrl.sv
module rtcp_ctrl
  import rtcp_pkg::*;
#(
  parameter int unsigned AW = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              en_n,
  input  logic              byte_vld,
  input  logic [BYTE_W-1:0] byte_val,
  input  logic              wp,
  input  logic [31:0]       secs,
  input  logic [BYTE_W-1:0] rd_data,
  output logic [AW-1:0]     rd_idx,
  output logic              load_out,
  output logic [BYTE_W-1:0] load_byte,
  output wr_kind_e          wr_kind,
  output logic [AW-1:0]     wr_idx,
  output logic [BYTE_W-1:0] wr_data
);
  phase_e            ph_q, ph_n;
  logic [BYTE_W-1:0] cmd_q, cmd_n;
  logic [AW-1:0]     xidx_q, xidx_n, xidx_calc;
  logic [BYTE_W-1:0] b;

  assign b = byte_val;
  assign xidx_calc = AW'({cmd_q[2:0], 3'b000}) + AW'(b[6:2]);

  always_comb begin
    if (ph_q == PH_XADDR)  rd_idx = xidx_calc;
    else if (b[6])         rd_idx = AW'(b[5:2]);
    else                   rd_idx = AW'({3'b100, b[3:2]});
  end

  always_comb begin
    ph_n      = ph_q;
    cmd_n     = cmd_q;
    xidx_n    = xidx_q;
    load_out  = 1'b0;
    load_byte = rd_data;
    wr_kind   = WR_NONE;
    wr_idx    = '0;
    wr_data   = b;
    if (en_n) begin
      ph_n = PH_CMD;
    end else if (byte_vld) begin
      unique case (ph_q)
        PH_CMD: begin
          cmd_n = b;
          if (b[7]) begin
            if (is_secs(b)) begin
              load_out  = 1'b1;
              load_byte = secs[8*b[3:2] +: 8];
            end else if (is_hi_pram(b) || is_lo_pram(b)) begin
              load_out = 1'b1;
            end else if (is_ext(b)) begin
              ph_n = PH_XADDR;
            end
          end else begin
            ph_n = is_ext(b) ? PH_XADDR : PH_WDATA;
          end
        end
        PH_WDATA: begin
          ph_n = PH_CMD;
          if (cmd_q == CMD_WPROT) begin
            wr_kind = WR_WP;
          end else if (!wp) begin
            if (is_secs(cmd_q)) begin
              wr_kind = WR_SECS;
              wr_idx  = AW'(cmd_q[3:2]);
            end else if (is_hi_pram(cmd_q)) begin
              wr_kind = WR_PRAM;
              wr_idx  = AW'({3'b100, cmd_q[3:2]});
            end else if (is_lo_pram(cmd_q)) begin
              wr_kind = WR_PRAM;
              wr_idx  = AW'(cmd_q[5:2]);
            end
          end
        end
        PH_XADDR: begin
          if (cmd_q[7]) begin
            load_out = 1'b1;
            ph_n     = PH_CMD;
          end else begin
            xidx_n = xidx_calc;
            ph_n   = PH_XWDATA;
          end
        end
        PH_XWDATA: begin
          ph_n = PH_CMD;
          if (!wp) begin
            wr_kind = WR_PRAM;
            wr_idx  = xidx_q;
          end
        end
        default: ph_n = PH_CMD;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph_q   <= PH_CMD;
      cmd_q  <= '0;
      xidx_q <= '0;
    end else begin
      ph_q   <= ph_n;
      cmd_q  <= cmd_n;
      xidx_q <= xidx_n;
    end
  end
endmodule

// File: rtl/rtcp_store.sv
module rtcp_store
  import rtcp_pkg::*;
#(
  parameter int unsigned DEPTH = 256,
  parameter int unsigned AW    = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sec_tick,
  input  logic              preset_stb,
  input  logic [31:0]       preset_unix,
  input  wr_kind_e          wr_kind,
  input  logic [AW-1:0]     wr_idx,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic [AW-1:0]     rd_idx,
  output logic [BYTE_W-1:0] rd_data,
  output logic [31:0]       secs,
  output logic              wp
);
  logic [31:0]       secs_q, secs_n;
  logic              wp_q, wp_n;
  logic [BYTE_W-1:0] mem [DEPTH];

  always_comb begin
    secs_n = secs_q;
    if (preset_stb)                secs_n = preset_unix + EPOCH_OFFSET;
    else if (wr_kind == WR_SECS)   secs_n[8*wr_idx[1:0] +: 8] = wr_data;
    else if (sec_tick)             secs_n = secs_q + 32'd1;
  end

  always_comb begin
    wp_n = wp_q;
    if (wr_kind == WR_WP) wp_n = wr_data[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      secs_q <= '0;
      wp_q   <= 1'b0;
    end else begin
      secs_q <= secs_n;
      wp_q   <= wp_n;
    end
  end

  always_ff @(posedge clk) begin
    if (wr_kind == WR_PRAM) mem[wr_idx] <= wr_data;
  end

  assign rd_data = mem[rd_idx];
  assign secs    = secs_q;
  assign wp      = wp_q;
endmodule

// File: rtl/serial_rtc_pram.sv
module serial_rtc_pram
  import rtcp_pkg::*;
#(
  parameter int unsigned PRAM_DEPTH = 256
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        sec_tick,
  input  logic        preset_stb,
  input  logic [31:0] preset_unix,
  input  logic        ser_en_n,
  input  logic        ser_clk,
  input  logic        ser_din,
  input  logic        host_drive,
  output logic        ser_dout
);
  localparam int unsigned AW = $clog2(PRAM_DEPTH);

  logic              byte_vld;
  logic [BYTE_W-1:0] byte_val;
  logic              load_out;
  logic [BYTE_W-1:0] load_byte;
  logic              wp;
  logic [31:0]       secs;
  logic [BYTE_W-1:0] rd_data;
  logic [AW-1:0]     rd_idx;
  wr_kind_e          wr_kind;
  logic [AW-1:0]     wr_idx;
  logic [BYTE_W-1:0] wr_data;

  rtcp_shifter u_shift (
    .clk(clk), .rst_n(rst_n), .en_n(ser_en_n), .sclk(ser_clk), .din(ser_din),
    .host_drive(host_drive), .load_out(load_out), .load_byte(load_byte),
    .byte_vld(byte_vld), .byte_val(byte_val), .dout(ser_dout)
  );

  rtcp_ctrl #(.AW(AW)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .en_n(ser_en_n), .byte_vld(byte_vld),
    .byte_val(byte_val), .wp(wp), .secs(secs), .rd_data(rd_data),
    .rd_idx(rd_idx), .load_out(load_out), .load_byte(load_byte),
    .wr_kind(wr_kind), .wr_idx(wr_idx), .wr_data(wr_data)
  );

  rtcp_store #(.DEPTH(PRAM_DEPTH), .AW(AW)) u_store (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .preset_stb(preset_stb),
    .preset_unix(preset_unix), .wr_kind(wr_kind), .wr_idx(wr_idx),
    .wr_data(wr_data), .rd_idx(rd_idx), .rd_data(rd_data), .secs(secs), .wp(wp)
  );
endmodule

// File: rtl/rtcp_checker.sv
module rtcp_checker
  import rtcp_pkg::*;
(
  input logic        clk,
  input logic        rst_n,
  input logic        ser_en_n,
  input logic        ser_clk,
  input logic        host_drive,
  input logic        ser_dout,
  input logic        byte_vld,
  input wr_kind_e    wr_kind,
  input logic        wp,
  input logic        sec_tick,
  input logic        preset_stb,
  input logic [31:0] preset_unix,
  input logic [31:0] secs
);
  // R1
  en_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ser_en_n |=> !byte_vld);

  // R3
  dout_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(ser_dout) |-> (!$past(ser_clk) && $past(ser_clk, 2) &&
                            !$past(host_drive) && !$past(ser_en_n)));

  // R8
  wp_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wp && wr_kind != WR_NONE) |-> wr_kind == WR_WP);

  // R6
  tick_inc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sec_tick && !preset_stb && wr_kind != WR_SECS) |=> secs == $past(secs) + 32'd1);

  // R7
  preset_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    preset_stb |=> secs == $past(preset_unix) + EPOCH_OFFSET);
endmodule

bind serial_rtc_pram rtcp_checker u_chk (
  .clk(clk), .rst_n(rst_n), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
  .host_drive(host_drive), .ser_dout(ser_dout), .byte_vld(byte_vld),
  .wr_kind(wr_kind), .wp(wp), .sec_tick(sec_tick), .preset_stb(preset_stb),
  .preset_unix(preset_unix), .secs(secs)
);

// File: tb/serial_rtc_pram_bench.sv
module serial_rtc_pram_bench;
  localparam int HALF = 4;
  localparam logic [31:0] OFFS = 32'd2082844800;

  logic clk = 1'b0;
  logic rst_n;
  logic sec_tick, preset_stb, ser_en_n, ser_clk, ser_din, host_drive;
  logic [31:0] preset_unix;
  logic ser_dout;

  int total = 0;
  int bad = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic [7:0] got_byte;
  event       got_ev;

  always #2 clk = ~clk;

  serial_rtc_pram u_serial_rtc_pram (
    .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .preset_stb(preset_stb),
    .preset_unix(preset_unix), .ser_en_n(ser_en_n), .ser_clk(ser_clk),
    .ser_din(ser_din), .host_drive(host_drive), .ser_dout(ser_dout)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // monitor: pops the expected item for each byte the host receives
  initial begin
    forever begin
      @(got_ev);
      if (exp_q.size() == 0) begin
        check("scoreboard-empty", 32'd1, 32'd0);
      end else begin
        logic [7:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, {24'd0, got_byte}, {24'd0, e});
      end
    end
  end

  task automatic wait_h(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic send_bit(input logic b);
    ser_din = b; wait_h(HALF);
    ser_clk = 1'b1; wait_h(HALF);
    ser_clk = 1'b0; wait_h(HALF);
  endtask

  task automatic send_byte(input logic [7:0] b);
    for (int i = 7; i >= 0; i--) send_bit(b[i]);
  endtask

  task automatic recv_byte(output logic [7:0] v);
    host_drive = 1'b0; wait_h(HALF);
    v = '0;
    for (int i = 0; i < 8; i++) begin
      ser_clk = 1'b1; wait_h(HALF);
      ser_clk = 1'b0; wait_h(HALF);
      v = {v[6:0], ser_dout};
    end
  endtask

  task automatic end_frame();
    host_drive = 1'b1; wait_h(HALF);
    ser_en_n = 1'b1; wait_h(2 * HALF);
  endtask

  task automatic wr2(input logic [7:0] c, input logic [7:0] d);
    ser_en_n = 1'b0; wait_h(HALF);
    send_byte(c); send_byte(d);
    end_frame();
  endtask

  task automatic wr3(input logic [7:0] c, input logic [7:0] a, input logic [7:0] d);
    ser_en_n = 1'b0; wait_h(HALF);
    send_byte(c); send_byte(a); send_byte(d);
    end_frame();
  endtask

  task automatic rd1(input logic [7:0] c, input logic [7:0] e, input string t);
    logic [7:0] v;
    exp_q.push_back(e); tag_q.push_back(t);
    ser_en_n = 1'b0; wait_h(HALF);
    send_byte(c); wait_h(HALF);
    recv_byte(v);
    end_frame();
    got_byte = v; -> got_ev; wait_h(1);
  endtask

  task automatic rd2(input logic [7:0] c, input logic [7:0] a, input logic [7:0] e, input string t);
    logic [7:0] v;
    exp_q.push_back(e); tag_q.push_back(t);
    ser_en_n = 1'b0; wait_h(HALF);
    send_byte(c); send_byte(a); wait_h(HALF);
    recv_byte(v);
    end_frame();
    got_byte = v; -> got_ev; wait_h(1);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    bad++; total++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    logic [31:0] pre;
    logic [7:0] v;
    rst_n = 1'b0; sec_tick = 1'b0; preset_stb = 1'b0; preset_unix = '0;
    ser_en_n = 1'b1; ser_clk = 1'b0; ser_din = 1'b0; host_drive = 1'b1;
    wait_h(5);
    rst_n = 1'b1;
    wait_h(3);

    // R12 reset state
    check("R12 dout after reset", {31'd0, ser_dout}, 32'd0);
    rd1(8'h81, 8'h00, "R12 seconds byte0 after reset");
    rd1(8'h8D, 8'h00, "R12 seconds byte3 after reset");

    // R10 and R2: plain memory windows
    wr2(8'h55, 8'h1E);
    rd1(8'hD5, 8'h1E, "R10 R2 low window idx 5");
    wr2(8'h29, 8'h6B);
    rd1(8'hA9, 8'h6B, "R10 high window idx 0x12");

    // R11 extended access, sector 3 offset 9 = idx 33
    wr3(8'h3B, 8'h24, 8'h77);
    rd2(8'hBB, 8'h24, 8'h77, "R11 ext read back");
    rd2(8'hBB, 8'hA7, 8'h77, "R11 ext addr unused bits ignored");
    // sector 2 offset 3 = idx 0x13, seen through plain high window
    wr3(8'h3A, 8'h0C, 8'h5E);
    rd1(8'hAD, 8'h5E, "R11 ext index vs plain idx 0x13");

    // R3 bit order and hold after 8 bits
    ser_en_n = 1'b0; wait_h(HALF);
    send_byte(8'hA9); wait_h(HALF);
    recv_byte(v);
    check("R3 msb first byte", {24'd0, v}, 32'h6B);
    ser_clk = 1'b1; wait_h(HALF); ser_clk = 1'b0; wait_h(HALF);
    check("R3 dout held after 8 bits", {31'd0, ser_dout}, 32'd1);
    end_frame();

    // R7 preset and R4 byte order
    pre = 32'h5D00_1234;
    preset_unix = pre; preset_stb = 1'b1; wait_h(1); preset_stb = 1'b0; wait_h(2);
    pre = pre + OFFS;
    rd1(8'h81, pre[7:0],   "R7 R4 seconds byte0");
    rd1(8'h85, pre[15:8],  "R7 R4 seconds byte1");
    rd1(8'h89, pre[23:16], "R7 R4 seconds byte2");
    rd1(8'h8D, pre[31:24], "R7 R4 seconds byte3");

    // R6 ticks
    for (int i = 0; i < 3; i++) begin
      sec_tick = 1'b1; wait_h(1); sec_tick = 1'b0; wait_h(2);
    end
    pre = pre + 32'd3;
    rd1(8'h81, pre[7:0], "R6 seconds after 3 ticks");

    // R5 single seconds byte write
    wr2(8'h09, 8'h42);
    pre[23:16] = 8'h42;
    rd1(8'h89, 8'h42,     "R5 written seconds byte2");
    rd1(8'h81, pre[7:0],  "R5 seconds byte0 untouched");
    rd1(8'h8D, pre[31:24],"R5 seconds byte3 untouched");

    // R9 test register discards data
    wr2(8'h31, 8'hFF);
    rd1(8'hD5, 8'h1E,     "R9 memory untouched by test write");
    rd1(8'h85, pre[15:8], "R9 seconds untouched by test write");

    // R8 write protect
    wr2(8'h35, 8'h01);
    wr2(8'h55, 8'h00);
    rd1(8'hD5, 8'h1E, "R8 plain write blocked");
    wr2(8'h05, 8'h00);
    rd1(8'h85, pre[15:8], "R8 seconds write blocked");
    wr3(8'h3B, 8'h24, 8'h00);
    rd2(8'hBB, 8'h24, 8'h77, "R8 ext write blocked");
    wr2(8'h35, 8'h00);
    wr2(8'h55, 8'h11);
    rd1(8'hD5, 8'h11, "R8 write allowed after clear");

    // R1 transfer with select high
    host_drive = 1'b1;
    send_byte(8'h55); send_byte(8'h99);
    wait_h(HALF);
    rd1(8'hD5, 8'h11, "R1 ignored while select high");
    // R1 abort of partial byte
    ser_en_n = 1'b0; wait_h(HALF);
    send_bit(1'b1); send_bit(1'b1); send_bit(1'b1); send_bit(1'b1);
    ser_en_n = 1'b1; wait_h(2 * HALF);
    wr2(8'h55, 8'h22);
    rd1(8'hD5, 8'h22, "R1 partial byte dropped");

    wait_h(10);
    check("scoreboard drained", exp_q.size(), 32'd0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule